// File: doc/BRIEF.md
# Runtime-Configurable SPI Master Byte Transceiver

This block is a single-master SPI engine that exchanges one byte with one selected slave per transfer. A one-cycle start request in the idle state captures five things: the clock polarity, the clock phase, a clock-divide value, a slave index and a transmit byte. The block then runs a full-duplex frame and clears its busy flag on its own when the frame ends. The serial clock is made from the system clock. It toggles once every D+1 system clocks, where D is the captured divide value.

A frame has sixteen serial-clock edges, the leading and trailing edge of each of eight bits. A 3-bit bit counter and a half-bit flag track them. Both directions move the most significant bit first. The phase setting decides which edges launch data and which edges sample it. Only the addressed active-low select line is driven low, and only while busy is high. The received byte appears on the output in the same clock edge that clears busy.

Top module: `spi_xcvr`

## Requirements
- R1: Reset is asynchronous and active low. While it is asserted, busy is 0, every ss_n bit is 1, sclk is 0 and rx_byte is 0.
- R2: When start is 1 at a rising clock edge while idle, busy is 1 from that edge on. Busy stays high for exactly 16*(D+1) clock cycles and then returns to 0 with no further input.
- R3: A start seen while busy is ignored. The divide, polarity, phase, address and transmit inputs are captured only when a transfer is accepted, so later changes to them do not alter the frame under way.
- R4: While idle, sclk takes the cpol input value one clock later. A frame begins and ends with sclk at the captured polarity.
- R5: Within a frame, sclk changes 16 times. Successive changes, and the first change after busy rises, are D+1 clock cycles apart.
- R6: While busy is 1, only ss_n[a] is 0, where a is the captured slave address. All other bits are 1. While busy is 0, all bits are 1.
- R7: Each frame is full duplex and MSB first. tx_byte bit 7 is sent first, and the first MISO bit sampled lands in rx_byte bit 7.
- R8: With cpha=0, tx bit 7 is on MOSI before the first sclk edge, MOSI changes on trailing edges and MISO is sampled on leading edges. With cpha=1, MOSI changes on every leading edge except the first, and MISO is sampled on trailing edges.
- R9: rx_byte is loaded with the received byte on the clock edge where busy falls and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a transfer, taken only when idle |
| cpol | input | 1 | Serial clock polarity (resting level) |
| cpha | input | 1 | Serial clock phase: 0 samples on leading edges, 1 on trailing edges |
| div_val | input | DIV_W | Divide value D; sclk toggles every D+1 clocks |
| slave_addr | input | ADDR_W | Index of the select line to drive low |
| tx_byte | input | DATA_W | Byte to send |
| rx_byte | output | DATA_W | Last byte received |
| busy | output | 1 | High while a frame is running |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out to the slaves |
| miso | input | 1 | Serial data in from the selected slave |
| ss_n | output | N_SLAVES | Active-low select lines, one per slave |

## Verification
Every output is registered. Busy and the chosen select line therefore change at the rising edge that samples start. The first sclk transition follows D+1 clocks after that edge, and each later transition follows another D+1 clocks. rx_byte, busy and all select lines all change together at the sixteenth transition. The bench drives inputs and reads outputs only on falling clock edges. It counts falling edges between sclk changes and between the rise and fall of busy, so each count is compared against D+1 or 16*(D+1) at the half cycle after the edge that produced it. The bench also models the slave: it moves MISO at the half cycle after each launching edge and samples MOSI at the half cycle after each sampling edge.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

   typedef enum logic {
      XS_IDLE = 1'b0,
      XS_RUN  = 1'b1
   } xs_state_t;

   // width of a select index for n slaves, never below one bit
   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/spi_xcvr_div.sv
module spi_xcvr_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] div_val,
   input  logic             run,
   output logic             tick
);

   logic [DIV_W-1:0] lim_q;
   logic [DIV_W-1:0] cnt_q;

   // a tick every lim_q+1 clocks while running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         lim_q <= div_val;
         cnt_q <= '0;
      end else if (run) begin
         if (cnt_q == lim_q) cnt_q <= '0;
         else                cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   assign tick = run && (cnt_q == lim_q);

endmodule

// File: rtl/spi_xcvr_ctrl.sv
module spi_xcvr_ctrl
   import spi_xcvr_pkg::*;
#(
   parameter  int DATA_W = 8,
   localparam int CNT_W  = $clog2(DATA_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cpol,
   input  logic cpha,
   input  logic tick,
   output logic busy,
   output logic launch,
   output logic last,
   output logic sample_en,
   output logic shift_en,
   output logic sclk
);

   localparam logic [CNT_W-1:0] BIT_MAX = CNT_W'(DATA_W - 1);

   xs_state_t        state_q;
   logic [CNT_W-1:0] bit_q;
   logic             trail_q;   // 0: next edge leads, 1: next edge trails
   logic             cpha_q;
   logic             sclk_q;
   logic             lead_tick;
   logic             trail_tick;

   assign busy       = (state_q == XS_RUN);
   assign launch     = (state_q == XS_IDLE) && start;
   assign lead_tick  = busy && tick && !trail_q;
   assign trail_tick = busy && tick && trail_q;
   assign last       = trail_tick && (bit_q == BIT_MAX);

   // phase picks which edge class samples and which launches
   assign sample_en = cpha_q ? trail_tick : lead_tick;
   assign shift_en  = cpha_q ? (lead_tick && (bit_q != '0))
                             : (trail_tick && !last);
   assign sclk      = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         bit_q   <= '0;
         trail_q <= 1'b0;
         cpha_q  <= 1'b0;
         sclk_q  <= 1'b0;
      end else begin
         unique case (state_q)
            XS_IDLE: begin
               sclk_q <= cpol;
               if (start) begin
                  state_q <= XS_RUN;
                  cpha_q  <= cpha;
                  bit_q   <= '0;
                  trail_q <= 1'b0;
               end
            end
            XS_RUN: begin
               if (tick) begin
                  sclk_q  <= ~sclk_q;
                  trail_q <= ~trail_q;
                  if (trail_q) bit_q <= bit_q + 1'b1;
                  if (last)    state_q <= XS_IDLE;
               end
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_xcvr_shreg.sv
module spi_xcvr_shreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              shift_en,
   input  logic              sample_en,
   input  logic              last,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_byte
);

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] rx_nxt;
   logic [DATA_W-1:0] rx_q;

   assign rx_nxt = sample_en ? {rx_sh[DATA_W-2:0], miso} : rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (launch) begin
         tx_sh <= tx_byte;
         rx_sh <= '0;
      end else begin
         if (shift_en) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
         rx_sh <= rx_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rx_q <= '0;
      else if (last) rx_q <= rx_nxt;
   end

   assign mosi    = tx_sh[DATA_W-1];
   assign rx_byte = rx_q;

endmodule

// File: rtl/spi_xcvr_sel.sv
module spi_xcvr_sel #(
   parameter int N_SLAVES = 4,
   parameter int ADDR_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch,
   input  logic                last,
   input  logic [ADDR_W-1:0]   slave_addr,
   output logic [N_SLAVES-1:0] ss_n
);

   for (genvar g = 0; g < N_SLAVES; g++) begin : g_line
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      line_q <= 1'b1;
         else if (launch) line_q <= (slave_addr != ADDR_W'(g));
         else if (last)   line_q <= 1'b1;
      end
      assign ss_n[g] = line_q;
   end

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
   import spi_xcvr_pkg::*;
#(
   parameter  int DATA_W   = 8,
   parameter  int N_SLAVES = 4,
   parameter  int DIV_W    = 8,
   localparam int ADDR_W   = sel_width(N_SLAVES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                cpol,
   input  logic                cpha,
   input  logic [DIV_W-1:0]    div_val,
   input  logic [ADDR_W-1:0]   slave_addr,
   input  logic [DATA_W-1:0]   tx_byte,
   output logic [DATA_W-1:0]   rx_byte,
   output logic                busy,
   output logic                sclk,
   output logic                mosi,
   input  logic                miso,
   output logic [N_SLAVES-1:0] ss_n
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("spi_xcvr: DATA_W must be a power of two, at least 2");
   end
   if (N_SLAVES < 1) begin : g_bad_slaves
      $error("spi_xcvr: N_SLAVES must be at least 1");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_xcvr: DIV_W must be at least 1");
   end

   logic tick;
   logic launch;
   logic last;
   logic sample_en;
   logic shift_en;

   spi_xcvr_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (launch),
      .div_val (div_val),
      .run     (busy),
      .tick    (tick)
   );

   spi_xcvr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cpol      (cpol),
      .cpha      (cpha),
      .tick      (tick),
      .busy      (busy),
      .launch    (launch),
      .last      (last),
      .sample_en (sample_en),
      .shift_en  (shift_en),
      .sclk      (sclk)
   );

   spi_xcvr_shreg #(.DATA_W(DATA_W)) u_shreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .tx_byte   (tx_byte),
      .shift_en  (shift_en),
      .sample_en (sample_en),
      .last      (last),
      .miso      (miso),
      .mosi      (mosi),
      .rx_byte   (rx_byte)
   );

   spi_xcvr_sel #(.N_SLAVES(N_SLAVES), .ADDR_W(ADDR_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .last       (last),
      .slave_addr (slave_addr),
      .ss_n       (ss_n)
   );

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
   parameter int DATA_W   = 8,
   parameter int N_SLAVES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                cpol,
   input logic                busy,
   input logic                sclk,
   input logic [N_SLAVES-1:0] ss_n,
   input logic [DATA_W-1:0]   rx_byte
);

   localparam int EW = $clog2(2 * DATA_W + 2) + 1;

   logic          prev_busy;
   logic          prev_sclk;
   logic [EW-1:0] n_edges;

   // counts sclk changes seen inside a frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_busy <= 1'b0;
         prev_sclk <= 1'b0;
         n_edges   <= '0;
      end else begin
         prev_busy <= busy;
         prev_sclk <= sclk;
         if (busy && !prev_busy)                  n_edges <= '0;
         else if (prev_busy && sclk != prev_sclk) n_edges <= n_edges + 1'b1;
      end
   end

   a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   a_r6_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ss_n == '1));

   a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(ss_n) == N_SLAVES - 1));

   a_r3_select_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ss_n));

   a_r9_rx_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !(!busy && $past(busy)) |-> $stable(rx_byte));

   a_r4_idle_follows_cpol: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !busy && !$past(busy)) |-> (sclk == $past(cpol)));

   a_r4_frame_starts_at_rest: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (sclk == $past(cpol)));

   a_r5_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_busy && !busy) |->
         ((int'(n_edges) + int'(sclk != prev_sclk)) == 2 * DATA_W));

endmodule

bind spi_xcvr spi_xcvr_chk #(.DATA_W(DATA_W), .N_SLAVES(N_SLAVES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .cpol    (cpol),
   .busy    (busy),
   .sclk    (sclk),
   .ss_n    (ss_n),
   .rx_byte (rx_byte)
);

// File: tb/spi_xcvr_test.sv
module spi_xcvr_test;

   localparam int NS = 4;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       cpol  = 1'b0;
   logic       cpha  = 1'b0;
   logic [7:0] div_val = '0;
   logic [1:0] slave_addr = '0;
   logic [7:0] tx_byte = '0;
   logic       miso = 1'b0;
   logic [7:0] rx_byte;
   logic       busy;
   logic       sclk;
   logic       mosi;
   logic [NS-1:0] ss_n;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spi_xcvr uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
      .div_val(div_val), .slave_addr(slave_addr), .tx_byte(tx_byte),
      .rx_byte(rx_byte), .busy(busy), .sclk(sclk), .mosi(mosi),
      .miso(miso), .ss_n(ss_n)
   );

   // fields: cpol[27] cpha[26] div[25:18] addr[17:16] tx[15:8] slave[7:0]
   localparam logic [27:0] VECS [8] = '{
      {1'b0, 1'b0, 8'd0, 2'd0, 8'hA5, 8'h3C},
      {1'b0, 1'b1, 8'd1, 2'd1, 8'h5A, 8'hC3},
      {1'b1, 1'b0, 8'd2, 2'd2, 8'h81, 8'h7E},
      {1'b1, 1'b1, 8'd3, 2'd3, 8'h0F, 8'hF0},
      {1'b0, 1'b0, 8'd4, 2'd3, 8'hFF, 8'h00},
      {1'b1, 1'b1, 8'd0, 2'd1, 8'h00, 8'hFF},
      {1'b0, 1'b1, 8'd2, 2'd0, 8'h96, 8'h69},
      {1'b1, 1'b0, 8'd1, 2'd2, 8'hC3, 8'h18}
   };

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_frame(input logic p, input logic h, input logic [7:0] d,
                            input logic [1:0] a, input logic [7:0] tx,
                            input logic [7:0] sv, input bit disturb);
      logic [NS-1:0] ss_exp = ~(NS'(1) << a);
      logic [7:0] srx = '0;
      logic [7:0] rx_before;
      logic prev;
      int cycles = 1, gap = 0, edges = 0, badgap = 0, ssbad = 0, rxbad = 0, guard = 0;
      string tag = disturb ? "R3" : "R7";
      @(negedge clk);
      cpol = p; cpha = h; div_val = d; slave_addr = a; tx_byte = tx;
      miso = sv[7]; start = 1'b1;
      rx_before = rx_byte;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R2 busy after start", busy, 1);
      chk(ss_n === ss_exp, "R6 select at start", ss_n, ss_exp);
      chk(sclk === p, "R4 sclk at frame start", sclk, p);
      prev = sclk;
      forever begin
         @(negedge clk);
         guard++;
         if (disturb) begin
            if (guard == 3) begin
               start = 1'b1; tx_byte = ~tx; slave_addr = a + 2'd1;
               cpol = ~p; cpha = ~h; div_val = d + 8'd3;
            end else if (guard == 6) begin
               start = 1'b0; tx_byte = tx; slave_addr = a;
               cpol = p; cpha = h; div_val = d;
            end
         end
         gap++;
         if (sclk !== prev) begin
            int e = edges;
            if (gap != int'(d) + 1) badgap++;
            edges++;
            gap = 0;
            prev = sclk;
            if (!h) begin
               if (e % 2 == 0) srx = {srx[6:0], mosi};
               else if (e < 15) miso = sv[7 - (e + 1) / 2];
            end else begin
               if (e % 2 == 0) miso = sv[7 - e / 2];
               else srx = {srx[6:0], mosi};
            end
         end
         if (busy !== 1'b1) break;
         cycles++;
         if (ss_n !== ss_exp) ssbad++;
         if (rx_byte !== rx_before) rxbad++;
         if (guard > 20000) begin
            chk(1'b0, "R2 frame never ended", guard, 16 * (int'(d) + 1));
            break;
         end
      end
      chk(edges == 16, "R5 edge count", edges, 16);
      chk(badgap == 0, "R5 edge spacing", badgap, 0);
      chk(cycles == 16 * (int'(d) + 1), "R2 busy length", cycles, 16 * (int'(d) + 1));
      chk(rx_byte === sv, {tag, " received byte"}, rx_byte, sv);
      chk(srx === tx, {tag, " R8 byte seen by slave"}, srx, tx);
      chk(ssbad == 0, "R6 select during frame", ssbad, 0);
      chk(rxbad == 0, "R9 rx held during frame", rxbad, 0);
      chk(ss_n === '1, "R6 deselect at end", ss_n, 4'hF);
      @(negedge clk);
      chk(sclk === p, "R4 sclk rests after frame", sclk, p);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // reset state
      repeat (2) @(negedge clk);
      chk(busy === 1'b0, "R1 busy in reset", busy, 0);
      chk(ss_n === '1, "R1 select in reset", ss_n, 4'hF);
      chk(sclk === 1'b0, "R1 sclk in reset", sclk, 0);
      chk(rx_byte === 8'h00, "R1 rx in reset", rx_byte, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         run_frame(VECS[i][27], VECS[i][26], VECS[i][25:18], VECS[i][17:16],
                   VECS[i][15:8], VECS[i][7:0], 1'b0);
      end

      // start and settings changed mid-frame are ignored
      run_frame(1'b0, 1'b0, 8'd2, 2'd1, 8'h6B, 8'hD2, 1'b1);

      // idle sclk follows cpol one clock later
      @(negedge clk) cpol = 1'b1;
      @(negedge clk);
      chk(sclk === 1'b1, "R4 idle sclk follows cpol high", sclk, 1);
      cpol = 1'b0;
      @(negedge clk);
      chk(sclk === 1'b0, "R4 idle sclk follows cpol low", sclk, 0);

      // asynchronous reset in the middle of a frame
      cpol = 1'b1; cpha = 1'b0; div_val = 8'd3; slave_addr = 2'd2;
      tx_byte = 8'h55; start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(busy === 1'b0, "R1 async reset busy", busy, 0);
      chk(ss_n === '1, "R1 async reset select", ss_n, 4'hF);
      chk(sclk === 1'b0, "R1 async reset sclk", sclk, 0);
      chk(rx_byte === 8'h00, "R1 async reset rx", rx_byte, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // recovery after reset
      run_frame(1'b1, 1'b0, 8'd0, 2'd0, 8'h3C, 8'hA5, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule